// File: doc/BRIEF.md
# Inter-Core Message Interrupt Controller

This block lets any of `NUM_CORES` processor cores post a short message to any core, including itself, and interrupt it. Software on a core writes a request word into its own control slot. The request names a destination core and carries a 16-bit payload. The controller records the sender and the payload in the destination's mailbox. It then holds that core's interrupt line high until the receiving core acknowledges through its own control slot.

The register window is byte addressed and gives each core one 8-byte pair: a write-only control word and a read-only status word. The controller has no interrupt inputs. It drives one level interrupt per core. The bus side is a single-cycle write strobe, and a read whose data appears one cycle after the request.

Top module: `ipi_mailbox`

## Requirements
- R1: For core c, the control word is at byte address 8*c and the status word is at 8*c+4. An address whose two low bits are not zero does not select any register.
- R2: A control write by core S with bit 30 set and a destination index D (bits 29..16) below `NUM_CORES` updates D's status word. Afterwards that word reads as bit 31 = 0, bit 30 (pending) = 1, bits 29..16 = S and bits 15..0 = the written payload.
- R3: Read data appears on `rd_data` in the cycle after `rd_en` is sampled high and is zero in every other cycle. A read returns the state from before a write made in the same cycle.
- R4: `irq_o[c]` is high exactly while core c's pending flag is set.
- R5: A control write by core C with bit 31 set clears only C's pending flag. C's source and payload fields keep their last values.
- R6: A message that reaches a destination whose pending flag is already set replaces the source and payload, and the flag stays set.
- R7: A send whose destination index is `NUM_CORES` or higher changes nothing.
- R8: When bits 31 and 30 are written together, the acknowledge of the writer's own flag happens first and the send happens after it. A core that sends to itself this way ends with its flag set and holding the new message.
- R9: Reading a control word returns zero.
- R10: A write to an unused address (an unaligned address, or an index at or beyond `NUM_CORES`) changes nothing. A read of an unused address returns zero.
- R11: Reset clears every pending flag, source field and payload, and all interrupt outputs.
- R12: A control write with neither bit 31 nor bit 30 set changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_o | output | NUM_CORES | Level interrupt per core |

## Verification
The hardest case to reach is the combined acknowledge-and-send write. This matters most when the sender targets itself, because the result depends on the order of the two updates. It also matters when the sender targets another core while its own message is still pending. The stimulus first has a core post to itself. It then writes both request bits together from the same core with a new payload, and then again toward a different core. After each step the status word is read back. A reference model that tracks mailbox state compares every interrupt line and every read word on each clock. It does this through directed steps and a long random phase that mixes invalid destinations, unaligned and out-of-range addresses, and reads in the same cycle as writes.

// File: rtl/ipi_mbox_pkg.sv
// Shared definitions for the inter-core mailbox controller.
// Holds the request-word field positions and the per-core mailbox record.
package ipi_mbox_pkg;

    localparam int ACK_BIT   = 31;
    localparam int SEND_BIT  = 30;
    localparam int ID_HI     = 29;
    localparam int ID_LO     = 16;
    localparam int ID_W      = ID_HI - ID_LO + 1;
    localparam int PAYLOAD_W = 16;

    // One mailbox: pending flag, sender index and payload.
    typedef struct packed {
        logic                 pend;
        logic [ID_W-1:0]      src;
        logic [PAYLOAD_W-1:0] payload;
    } mbox_t;

    // Builds the status word read by software. The top bit is always zero.
    function automatic logic [31:0] status_word(input mbox_t m);
        return {1'b0, m.pend, m.src, m.payload};
    endfunction

endpackage

// File: rtl/ipi_addr_decode.sv
// Register-window address decoder.
// Splits a byte address into core index and word select. Assumes
// 8 bytes per core and word alignment, and flags every other address as a miss.
module ipi_addr_decode #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8,
    parameter int CORE_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              is_status,
    output logic [CORE_W-1:0] core
);
    localparam int SLOT_W = ADDR_W - 3;

    logic [SLOT_W-1:0] slot_raw;

    // Separate the address into its slot, word and byte parts.
    always_comb begin
        slot_raw  = addr[ADDR_W-1:3];
        is_status = addr[2];
        core      = slot_raw[CORE_W-1:0];
        hit       = (addr[1:0] == 2'b00) &&
                    ({{(32-SLOT_W){1'b0}}, slot_raw} < 32'(NUM_CORES));
    end

endmodule

// File: rtl/ipi_mbox_slot.sv
// One destination mailbox.
// A delivery always wins over an acknowledge in the same cycle, which puts the
// acknowledge first and the send second. An acknowledge clears only the flag.
module ipi_mbox_slot
    import ipi_mbox_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 deliver,
    input  logic                 ack,
    input  logic [ID_W-1:0]      src_in,
    input  logic [PAYLOAD_W-1:0] payload_in,
    output mbox_t                box
);

    // Hold, deliver or acknowledge the single message kept for this core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            box <= '0;
        end else if (deliver) begin
            box.pend    <= 1'b1;
            box.src     <= src_in;
            box.payload <= payload_in;
        end else if (ack) begin
            box.pend <= 1'b0;
        end
    end

endmodule

// File: rtl/ipi_mailbox.sv
// Inter-core message interrupt controller, top level.
// Decodes control writes into per-core send and acknowledge strobes, keeps one
// mailbox per core, drives one level interrupt per core and serves registered
// status reads. Assumes 8*NUM_CORES <= 2**ADDR_W and NUM_CORES <= 2**14.
module ipi_mailbox
    import ipi_mbox_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [31:0]          rd_data,
    output logic [NUM_CORES-1:0] irq_o
);
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    logic              wr_hit, wr_is_status;
    logic [CORE_W-1:0] wr_core;
    logic              rd_hit, rd_is_status;
    logic [CORE_W-1:0] rd_core;

    logic                 ctrl_wr, req_ack, req_send, dst_ok;
    logic [ID_W-1:0]      dst_id, src_id;
    logic [PAYLOAD_W-1:0] req_payload;

    mbox_t boxes [NUM_CORES];

    ipi_addr_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .CORE_W(CORE_W)) wr_dec_i (
        .addr      (wr_addr),
        .hit       (wr_hit),
        .is_status (wr_is_status),
        .core      (wr_core)
    );

    ipi_addr_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .CORE_W(CORE_W)) rd_dec_i (
        .addr      (rd_addr),
        .hit       (rd_hit),
        .is_status (rd_is_status),
        .core      (rd_core)
    );

    // Split a control write into its request fields and check the destination.
    always_comb begin
        ctrl_wr     = wr_en && wr_hit && !wr_is_status;
        req_ack     = wr_data[ACK_BIT];
        req_send    = wr_data[SEND_BIT];
        dst_id      = wr_data[ID_HI:ID_LO];
        req_payload = wr_data[PAYLOAD_W-1:0];
        src_id      = ID_W'(wr_core);
        dst_ok      = {{(32-ID_W){1'b0}}, dst_id} < 32'(NUM_CORES);
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_box
        logic deliver_c, ack_c;

        // Send strobe when this core is the destination, acknowledge when it wrote.
        always_comb begin
            deliver_c = ctrl_wr && req_send && dst_ok && (dst_id == ID_W'(c));
            ack_c     = ctrl_wr && req_ack && (wr_core == CORE_W'(c));
        end

        ipi_mbox_slot slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .deliver    (deliver_c),
            .ack        (ack_c),
            .src_in     (src_id),
            .payload_in (req_payload),
            .box        (boxes[c])
        );

        // The interrupt level follows the pending flag.
        assign irq_o[c] = boxes[c].pend;
    end

    // Registered read: status words give the mailbox, everything else gives zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en && rd_hit && rd_is_status) begin
            rd_data <= status_word(boxes[rd_core]);
        end else begin
            rd_data <= '0;
        end
    end

endmodule

// File: rtl/ipi_mailbox_chk.sv
// Port-level property checker for ipi_mailbox, attached by bind.
// Decodes the write request on its own and checks interrupt and read behaviour.
module ipi_mailbox_chk #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [15:0]          wr_cmd,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    rd_addr,
    input logic [31:0]          rd_data,
    input logic [NUM_CORES-1:0] irq_o
);
    logic                 wr_aligned, wr_in_range, rd_in_range, c_wr, c_ack, c_send, c_dst_ok;
    logic [NUM_CORES-1:0] dst_mask, own_mask;
    logic [ADDR_W-4:0]    wr_slot, rd_slot;

    // Decode the bus request independently of the design.
    always_comb begin
        wr_slot     = wr_addr[ADDR_W-1:3];
        rd_slot     = rd_addr[ADDR_W-1:3];
        wr_aligned  = (wr_addr[1:0] == 2'b00);
        wr_in_range = (int'(wr_slot) < NUM_CORES);
        rd_in_range = (int'(rd_slot) < NUM_CORES);
        c_wr        = wr_en && wr_aligned && !wr_addr[2] && wr_in_range;
        c_ack       = wr_cmd[15];
        c_send      = wr_cmd[14];
        c_dst_ok    = (int'(wr_cmd[13:0]) < NUM_CORES);
        dst_mask    = c_dst_ok ? (NUM_CORES'(1) << wr_cmd[13:0]) : '0;
        own_mask    = NUM_CORES'(1) << wr_slot;
    end

    // R4
    send_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_send && c_dst_ok) |=> ((irq_o & $past(dst_mask)) != '0));

    // R5
    ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_ack && !c_send) |=> ((irq_o & $past(own_mask)) == '0));

    // R7
    bad_dst_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_send && !c_dst_ok && !c_ack) |=> $stable(irq_o));

    // R10
    unused_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_aligned && wr_in_range)) |=> $stable(irq_o));

    // R12
    empty_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && !c_ack && !c_send) |=> $stable(irq_o));

    // R3
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    // R9
    ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr[2:0] == 3'b000 && rd_in_range) |=> (rd_data == '0));

    // R11
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (irq_o == '0 && rd_data == '0));

endmodule

bind ipi_mailbox ipi_mailbox_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_cmd  (wr_data[31:16]),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq_o   (irq_o)
);

// File: tb/ipi_mailbox_tb_top.sv
// Bench for ipi_mailbox: a behavioural mailbox model compared on every clock,
// plus directed steps with hand-computed expected words.
module ipi_mailbox_tb_top;
    localparam int N  = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [N-1:0]  irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state
    int          m_pend [N];
    int          m_src  [N];
    int          m_pay  [N];
    logic [31:0] m_rd;

    always #5 clk = ~clk;

    ipi_mailbox #(.NUM_CORES(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Behavioural model: read sees the old state, then the write acts.
    always @(posedge clk) begin
        logic [31:0] nrd;
        int s, d;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_src[i] = 0; m_pay[i] = 0; end
            m_rd = 0;
        end else begin
            nrd = 0;
            if (rd_en && (rd_addr % 8) == 4 && (rd_addr / 8) < N) begin
                s = rd_addr / 8;
                nrd = {1'b0, m_pend[s][0], m_src[s][13:0], m_pay[s][15:0]};
            end
            if (wr_en && (wr_addr % 8) == 0 && (wr_addr / 8) < N) begin
                s = wr_addr / 8;
                d = int'(wr_data[29:16]);
                if (wr_data[31]) m_pend[s] = 0;
                if (wr_data[30] && d < N) begin
                    m_pend[d] = 1; m_src[d] = s; m_pay[d] = int'(wr_data[15:0]);
                end
            end
            m_rd = nrd;
        end
    end

    // Compare outputs with the model on every clock.
    always @(negedge clk) begin
        logic [31:0] exp_irq;
        if (rst_n && !done) begin
            exp_irq = '0;
            for (int i = 0; i < N; i++) exp_irq[i] = m_pend[i][0];
            check("R4 irq level", 32'(irq_o), exp_irq);
            check("R3 read data", rd_data, m_rd);
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd_expect(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); rd_en = 1; rd_addr = a;
        @(negedge clk); rd_en = 0;
        check(tag, rd_data, exp);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        check("R11 irq after reset", 32'(irq_o), 32'h0);
        rd_expect(8'h04, 32'h0, "R11 status after reset");
        // R2, R4: core1 -> core2, payload BEEF
        wr(8'h08, 32'h4002_BEEF);
        check("R4 irq core2", 32'(irq_o), 32'h4);
        rd_expect(8'h14, 32'h4001_BEEF, "R2 status core2");
        // R9: control word reads zero
        rd_expect(8'h10, 32'h0, "R9 ctrl read");
        // R6: core3 -> core2 overwrites
        wr(8'h18, 32'h4002_1234);
        rd_expect(8'h14, 32'h4003_1234, "R6 overwrite");
        // R5: core0 ack leaves core2, core2 ack clears only flag
        wr(8'h00, 32'h8000_0000);
        check("R5 foreign ack", 32'(irq_o), 32'h4);
        wr(8'h10, 32'h8000_0000);
        check("R5 own ack irq", 32'(irq_o), 32'h0);
        rd_expect(8'h14, 32'h0003_1234, "R5 fields kept");
        // R7: destination 4 out of range
        wr(8'h00, 32'h4004_0055);
        check("R7 bad dst", 32'(irq_o), 32'h0);
        // R8: self send, then ack+send to self, then ack+send elsewhere
        wr(8'h08, 32'h4001_000A);
        rd_expect(8'h0C, 32'h4001_000A, "R8 self send");
        wr(8'h08, 32'hC001_000B);
        rd_expect(8'h0C, 32'h4001_000B, "R8 ack then self send");
        wr(8'h08, 32'hC000_0077);
        check("R8 ack then send irq", 32'(irq_o), 32'h1);
        rd_expect(8'h0C, 32'h0001_000B, "R8 own flag cleared");
        // R1: status of core0 at 8*0+4
        rd_expect(8'h04, 32'h4001_0077, "R1 status map");
        // R10: unused and unaligned addresses
        wr(8'h40, 32'h4003_0001);
        wr(8'h01, 32'h4003_0002);
        check("R10 unused write", 32'(irq_o), 32'h1);
        rd_expect(8'h44, 32'h0, "R10 unused read");
        rd_expect(8'h05, 32'h0, "R1 unaligned read");
        // R12: no request bits
        wr(8'h00, 32'h0002_FFFF);
        check("R12 empty request", 32'(irq_o), 32'h1);
        // R3: idle cycle reads zero
        @(negedge clk);
        check("R3 idle rd_data", rd_data, 32'h0);
        // Random phase, model compared each clock
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            wr_en   = ($urandom % 3) == 0;
            wr_addr = AW'((($urandom % 6) * 8) + ((($urandom % 8) == 0) ? ($urandom % 8) : 0));
            wr_data = {1'($urandom % 2), 1'($urandom % 2), 14'($urandom % 6), 16'($urandom)};
            rd_en   = ($urandom % 2) == 0;
            rd_addr = AW'((($urandom % 6) * 8) + ((($urandom % 4) == 0) ? 0 : 4));
        end
        @(negedge clk); wr_en = 0; rd_en = 0;
        // R11: reset mid-run
        wr(8'h00, 32'h4003_0009);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R11 irq after late reset", 32'(irq_o), 32'h0);
        rd_expect(8'h1C, 32'h0, "R11 status after late reset");
        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule